// File: doc/BRIEF.md
# Single-Channel PWM Generator with Lockable Staged Updates

This block produces one pulse-width-modulated output from a free-running up-counter and three programmable settings: the period length, the duty length and the output levels. Software reaches it through a small APB-style register slave with four 32-bit registers: the live count at offset 0x00, period at 0x04, duty at 0x08 and control at 0x0C. Period and duty are counted in input clock ticks, with no prescaling.

New period and duty values, together with the two level bits (duty polarity and inactive level), are never applied in the middle of a period. Writes land in staging registers. The staged set moves into the working set at a period boundary, or on any cycle while the channel is stopped. Control bit 6 is a lock. While it is set, no transfer happens, so software can rewrite period, duty and polarity piecewise. Clearing the lock releases all of them together at the next boundary, which removes output glitches when the polarity changes on a running channel.

The sequencer has two named states. STOPPED holds the counter at 0 and transfers staged settings every cycle unless locked. RUNNING counts from 0 to period-1 and wraps. The transition GO (STOPPED to RUNNING) fires when the run condition holds. The transition HALT (RUNNING to STOPPED) fires when the run condition fails. The transition WRAP (RUNNING to RUNNING, counter back to 0) fires on the last count of a period and marks the boundary.

Top module: `pwm_lk_top`

## Requirements
- R1: After reset the period, duty, control and counter registers read 0 and the output is low.
- R2: A write to 0x04, 0x08 or 0x0C reads back the written value at the same offset, period and duty returning the staged value. Offset 0x00 returns the live count, and a write to 0x00 has no effect.
- R3: The channel runs only when control bit 0 is 1, bits 2:1 are 01 (continuous), bit 5 (alignment) is 0 and bit 8 (low-power) is 0. In every other case the counter reads 0 and the output equals control bit 4.
- R4: While running, the counter steps by one each clock from 0 up to working period minus 1 and then returns to 0. A working period of 0 or 1 keeps it at 0.
- R5: While running, the output takes the working polarity level (control bit 3: 1 = high during duty, 0 = low during duty) while counter < working duty, and the working inactive level (bit 4: 1 = high, 0 = low) otherwise. A duty at or above the period keeps the output active throughout.
- R6: With the lock clear on a running channel, written period, duty, bit 3 and bit 4 become working values only at the clock where the counter wraps to 0, never mid-period.
- R7: While control bit 6 is 1, the working period, duty and levels do not change, across any number of period boundaries and also while stopped.
- R8: After bit 6 is cleared, the staged period, duty and level bits all take effect together at the next wrap.
- R9: While stopped with the lock clear, staged values become working values on the next clock, so a newly started channel uses the latest settings from its first count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data for paddr (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong working period shows up as a counter readback that wraps at the wrong value within one period of the error. A wrong working duty or level bit flips pwm_out on the first cycle where the counter crosses the duty. A transfer that ignores the lock or fires mid-period changes the pulse shape inside the period where it happens, and the bench compares every cycle. A sequencer stuck in the wrong state shows on the next clock as a non-zero count while stopped or a frozen count while running.

// File: rtl/pwm_lk_pkg.sv
package pwm_lk_pkg;

    localparam int unsigned OFS_CNT  = 'h00;
    localparam int unsigned OFS_PER  = 'h04;
    localparam int unsigned OFS_DUTY = 'h08;
    localparam int unsigned OFS_CTRL = 'h0C;

    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_MODE   = 1;
    localparam int unsigned B_POL    = 3;
    localparam int unsigned B_INACT  = 4;
    localparam int unsigned B_ALIGN  = 5;
    localparam int unsigned B_LOCK   = 6;
    localparam int unsigned B_LP     = 8;

    localparam logic [1:0] MODE_CONT = 2'b01;

    typedef enum logic [0:0] {
        PH_STOPPED = 1'b0,
        PH_RUNNING = 1'b1
    } phase_t;

    typedef struct packed {
        logic       lp_on;
        logic       lock;
        logic       align_alt;
        logic       inact;
        logic       pol;
        logic [1:0] mode;
        logic       en;
    } ctl_t;

endpackage

// File: rtl/pwm_lk_regs.sv
module pwm_lk_regs
    import pwm_lk_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] per_s,
    output logic [DATA_W-1:0] duty_s,
    output ctl_t              ctl
);

    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PER);
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(OFS_DUTY);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic [DATA_W-1:0] ctrl_q;
    logic              wr_en;

    assign wr_en = psel & penable & pwrite;

    // Staging registers; the counter offset is read-only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_s  <= '0;
            duty_s <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (paddr)
                A_PER:   per_s  <= pwdata;
                A_DUTY:  duty_s <= pwdata;
                A_CTRL:  ctrl_q <= pwdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (paddr)
            A_CNT:   prdata = cnt;
            A_PER:   prdata = per_s;
            A_DUTY:  prdata = duty_s;
            A_CTRL:  prdata = ctrl_q;
            default: prdata = '0;
        endcase
    end

    assign ctl.en        = ctrl_q[B_EN];
    assign ctl.mode      = ctrl_q[B_MODE+1:B_MODE];
    assign ctl.pol       = ctrl_q[B_POL];
    assign ctl.inact     = ctrl_q[B_INACT];
    assign ctl.align_alt = ctrl_q[B_ALIGN];
    assign ctl.lock      = ctrl_q[B_LOCK];
    assign ctl.lp_on     = ctrl_q[B_LP];

endmodule

// File: rtl/pwm_lk_seq.sv
module pwm_lk_seq
    import pwm_lk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_ok,
    input  logic [DATA_W-1:0] per_a,
    output logic [DATA_W-1:0] cnt,
    output logic              run_q,
    output logic              wrap
);

    localparam int EXT_W = DATA_W + 1;

    phase_t phase_q, phase_d;
    logic [EXT_W-1:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt} + EXT_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_STOPPED;
        else        phase_q <= phase_d;
    end

    // Next state: GO, HALT, WRAP/count
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_STOPPED: if (run_ok)  phase_d = PH_RUNNING;
            PH_RUNNING: if (!run_ok) phase_d = PH_STOPPED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run_q = 1'b0;
        wrap  = 1'b0;
        unique case (phase_q)
            PH_STOPPED: run_q = 1'b0;
            PH_RUNNING: begin
                run_q = 1'b1;
                wrap  = (cnt_inc >= {1'b0, per_a});
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run_q && run_ok && !wrap) begin
            cnt <= cnt_inc[DATA_W-1:0];
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/pwm_lk_shadow.sv
module pwm_lk_shadow #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] per_s,
    input  logic [DATA_W-1:0] duty_s,
    input  logic              pol_s,
    input  logic              inact_s,
    output logic [DATA_W-1:0] per_a,
    output logic [DATA_W-1:0] duty_a,
    output logic              pol_a,
    output logic              inact_a
);

    // One transfer moves the whole set at once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_a   <= '0;
            duty_a  <= '0;
            pol_a   <= 1'b0;
            inact_a <= 1'b0;
        end else if (take) begin
            per_a   <= per_s;
            duty_a  <= duty_s;
            pol_a   <= pol_s;
            inact_a <= inact_s;
        end
    end

endmodule

// File: rtl/pwm_lk_wave.sv
module pwm_lk_wave #(
    parameter int DATA_W = 32
) (
    input  logic              run_q,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] duty_a,
    input  logic              pol_a,
    input  logic              inact_a,
    input  logic              inact_live,
    output logic              pwm_out
);

    logic in_duty;

    assign in_duty = (cnt < duty_a);

    always_comb begin
        if (!run_q)       pwm_out = inact_live;
        else if (in_duty) pwm_out = pol_a;
        else              pwm_out = inact_a;
    end

endmodule

// File: rtl/pwm_lk_top.sv
module pwm_lk_top
    import pwm_lk_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pwm_out
);

    ctl_t              ctl;
    logic [DATA_W-1:0] per_s, duty_s, per_a, duty_a, cnt;
    logic              pol_a, inact_a;
    logic              run_ok, run_q, wrap, take, lock_q;

    assign run_ok = ctl.en && (ctl.mode == MODE_CONT) && !ctl.align_alt && !ctl.lp_on;
    assign lock_q = ctl.lock;
    assign take   = !lock_q && (!run_q || wrap);

    pwm_lk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .cnt(cnt),
        .prdata(prdata), .per_s(per_s), .duty_s(duty_s), .ctl(ctl)
    );

    pwm_lk_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .per_a(per_a),
        .cnt(cnt), .run_q(run_q), .wrap(wrap)
    );

    pwm_lk_shadow #(.DATA_W(DATA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .take(take),
        .per_s(per_s), .duty_s(duty_s), .pol_s(ctl.pol), .inact_s(ctl.inact),
        .per_a(per_a), .duty_a(duty_a), .pol_a(pol_a), .inact_a(inact_a)
    );

    pwm_lk_wave #(.DATA_W(DATA_W)) u_wave (
        .run_q(run_q), .cnt(cnt), .duty_a(duty_a), .pol_a(pol_a),
        .inact_a(inact_a), .inact_live(ctl.inact), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwm_lk_chk.sv
module pwm_lk_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_q,
    input logic              run_ok,
    input logic              lock_q,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] per_a,
    input logic [DATA_W-1:0] duty_a,
    input logic              pol_a
);

    // R3
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> cnt == '0);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && per_a != '0) |-> cnt < per_a);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) && $past(run_ok) &&
         ({1'b0, $past(cnt)} + 1 < {1'b0, $past(per_a)}))
        |-> cnt == $past(cnt) + 1'b1);

    // R6
    mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && cnt != '0)
        |-> ($stable(duty_a) && $stable(per_a) && $stable(pol_a)));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(per_a) && $stable(duty_a) && $stable(pol_a)));

endmodule

bind pwm_lk_top pwm_lk_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .run_ok(run_ok),
    .lock_q(lock_q), .cnt(cnt), .per_a(per_a), .duty_a(duty_a), .pol_a(pol_a)
);

// File: tb/tb_pwm_lk_top.sv
module tb_pwm_lk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = 4'h0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pwm_out;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    fin = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_cnt, m_per, m_duty, s_per, s_duty, m_ctrl;
    bit          m_pol, m_ina, m_run;

    pwm_lk_top dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; s_per = 0; s_duty = 0;
            m_ctrl = 0; m_pol = 0; m_ina = 0; m_run = 0;
        end else begin
            bit run_ok, wrap, take;
            logic [32:0] nxt;
            run_ok = m_ctrl[0] && (m_ctrl[2:1] == 2'b01) && !m_ctrl[5] && !m_ctrl[8];
            nxt    = {1'b0, m_cnt} + 33'd1;
            wrap   = m_run && (nxt >= {1'b0, m_per});
            take   = !m_ctrl[6] && (!m_run || wrap);
            if (take) begin
                m_per = s_per; m_duty = s_duty; m_pol = m_ctrl[3]; m_ina = m_ctrl[4];
            end
            m_cnt = (m_run && run_ok && !wrap) ? nxt[31:0] : 32'd0;
            m_run = run_ok;
            if (psel && penable && pwrite) begin
                case (paddr)
                    4'h4: s_per  = pwdata;
                    4'h8: s_duty = pwdata;
                    4'hC: m_ctrl = pwdata;
                    default: ;
                endcase
            end
        end
    end

    // compare every clock, half a cycle after the edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            logic exp_out;
            exp_out = m_run ? ((m_cnt < m_duty) ? m_pol : m_ina) : m_ctrl[4];
            chk({cur_req, " pwm_out"}, {31'd0, pwm_out}, {31'd0, exp_out});
            if (paddr == 4'h0) chk("R4 count", prdata, m_cnt);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #2;
        psel = 0; penable = 0; pwrite = 0; paddr = 4'h0; pwdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        psel = 1; penable = 1; pwrite = 0; paddr = a;
        @(negedge clk);
        chk(tag, prdata, exp);
        @(posedge clk); #2;
        psel = 0; penable = 0; paddr = 4'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !fin) begin
            fin = 1'b1;
            n_bad++; n_cmp++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3); #2 rst_n = 1'b1;
        // R1 reset values
        cur_req = "R1";
        rd(4'h4, 0, "R1 period"); rd(4'h8, 0, "R1 duty");
        rd(4'hC, 0, "R1 ctrl");   rd(4'h0, 0, "R1 count");
        chk("R1 out", {31'd0, pwm_out}, 32'd0);
        // R2 register map
        cur_req = "R2";
        wr(4'h4, 10); wr(4'h8, 3);
        rd(4'h4, 10, "R2 period"); rd(4'h8, 3, "R2 duty");
        wr(4'h0, 77); rd(4'h0, 0, "R2 count write ignored");
        // R9 stopped transfer and idle level
        cur_req = "R9";
        wr(4'hC, 32'h10); idle(3); wr(4'hC, 32'h0); idle(2);
        // R5 normal polarity run
        cur_req = "R5";
        wr(4'hC, 32'h0B); idle(35);
        rd(4'hC, 32'h0B, "R2 ctrl");
        // R6 unlocked mid-period updates
        cur_req = "R6";
        idle(4); wr(4'h8, 7); idle(25);
        wr(4'h4, 5); idle(20);
        cur_req = "R5";
        wr(4'h8, 9); idle(15);
        wr(4'h8, 2); idle(10);
        // R3 run condition
        cur_req = "R3";
        wr(4'hC, 32'h2B);  idle(5);
        wr(4'hC, 32'h3B);  idle(5);
        wr(4'hC, 32'h10B); idle(5);
        wr(4'hC, 32'h0D);  idle(5);
        wr(4'hC, 32'h1A);  idle(5);
        wr(4'hC, 32'h0B);  idle(12);
        // R7 lock holds everything
        cur_req = "R7";
        wr(4'hC, 32'h4B); wr(4'h4, 6); wr(4'h8, 4);
        wr(4'hC, 32'h53); idle(30);
        rd(4'h4, 6, "R2 staged period");
        // R8 release together
        cur_req = "R8";
        wr(4'hC, 32'h13); idle(30);
        // R7 lock while stopped, then start under lock
        cur_req = "R7";
        wr(4'hC, 32'h40); wr(4'h4, 4); wr(4'h8, 1);
        wr(4'hC, 32'h4B); idle(20);
        cur_req = "R8";
        wr(4'hC, 32'h0B); idle(20);
        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule